// File: doc/BRIEF.md
# PCI Interrupt Swizzle Router

This block gathers the level-sensitive interrupt requests of a set of PCI devices and folds them onto the four interrupt lines of a host bridge. Each source comes with three inputs: its request level, its static identifier word, and the interrupt pin it uses (0 to 3). The router takes the slot number from the identifier word, adds the pin number, and keeps the sum modulo four. The result is a rotated line index, so devices in neighbouring slots spread their pins across different lines.

Every line output is the OR of all active sources that rotate onto it. A line is registered one clock after its inputs. Next to the four line levels, the block presents the fixed interrupt-controller input number of each line, so the controller side can wire each level to the right input. Edge detection, masking and the controller are outside the block.

Top module: `intx_swizzle_router`

## Requirements
- R1: The slot number of a source is the 5-bit field at bits 15:11 of its 16-bit identifier word. All other identifier bits have no effect on routing.
- R2: A source with slot `s` and pin `p` drives line index `(s + p) mod 4`. Line index `k` appears on `line_level[k]`.
- R3: Line index `k` carries controller input number `0x1B + k` on byte `k` of `line_vec` (bits `8k+7:8k`). That gives 0x1B, 0x1C, 0x1D and 0x1E for indices 0 to 3.
- R4: Requests are levels. Raising a lone source's request drives its line high. Lowering it drives the line low again.
- R5: When several active sources map to one line, that line is high. Lines that no active source maps to stay low.
- R6: A shared line stays high while any one of its mapped sources is still active. It goes low only once all of them are low.
- R7: A change at the inputs reaches `line_level` exactly one clock later, not earlier.
- R8: A synchronous active-high `rst` clears all four line levels to low on the next clock edge.
- R9: Only the low two bits of the slot matter. Slots 4 and 0 route alike, and slot 31 with pin 1 wraps to index 0.
- R10: The index sum wraps past 3: slot 3 with pin 3 lands on index 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | N_SRC | Request level of each source |
| src_id | input | N_SRC*16 | Identifier word of each source, source `i` at bits `16i+15:16i` |
| src_pin | input | N_SRC*2 | Interrupt pin of each source, source `i` at bits `2i+1:2i` |
| line_level | output | 4 | Registered level of each of the four lines, bit `k` for index `k` |
| line_vec | output | 32 | Controller input number of each line, byte `k` for index `k` |

## Verification
Single sources are swept over slot and pin pairs, including a plain sum, a sum that wraps past 3, a slot above 3 and the top slot 31. These cases separate a correct modulo-4 rotation from one that ignores the slot, ignores the pin, or uses the wrong slot bits. Filler bits placed below the slot field in the identifier word expose an off-by-one field position. Groups of sources that collide on one line are then released one at a time, which distinguishes an OR merge from a last-writer or XOR merge. A one-source step is sampled before and after the clock edge to pin down the single cycle of latency.

// File: rtl/irqsw_pkg.sv
`timescale 1ns/1ps
package irqsw_pkg;
   // The bus always has four interrupt lines; the index is two bits wide.
   localparam int LINES  = 4;
   localparam int LIDX_W = $clog2(LINES);
   // Interrupt pin number width (pins 0..3).
   localparam int PIN_W  = 2;

   typedef logic [LIDX_W-1:0] lidx_t;
   typedef logic [LINES-1:0]  lines_t;
endpackage

// File: rtl/irqsw_lane_decode.sv
`timescale 1ns/1ps
// Per-source decode: slot field plus pin, modulo the line count, as a one-hot
// request gated by the source level.
module irqsw_lane_decode
   import irqsw_pkg::*;
#(
   parameter int ID_W     = 16,
   parameter int SLOT_LSB = 11,
   parameter int SLOT_W   = 5
) (
   input  logic [ID_W-1:0]  dev_id,
   input  logic [PIN_W-1:0] pin,
   input  logic             level,
   output lines_t           req
);
   localparam int SUM_W  = SLOT_W + 1;
   localparam int SLOT_HI = SLOT_LSB + SLOT_W;

   if (SLOT_W < LIDX_W) begin : g_bad_slot
      $error("irqsw_lane_decode: SLOT_W must cover the line index");
   end
   if (SLOT_HI > ID_W) begin : g_bad_field
      $error("irqsw_lane_decode: slot field lies outside the identifier word");
   end

   logic [SLOT_W-1:0] slot;
   logic [SUM_W-1:0]  sum;
   lidx_t             idx;

   assign slot = dev_id[SLOT_LSB +: SLOT_W];
   assign sum  = {1'b0, slot} + SUM_W'(pin);
   assign idx  = sum[LIDX_W-1:0];

   always_comb begin
      req = '0;
      if (level) begin
         req[idx] = 1'b1;
      end
   end

   // Bits that play no part in routing are gathered here on purpose.
   logic unused_sum_hi;
   assign unused_sum_hi = ^sum[SUM_W-1:LIDX_W];

   if (SLOT_LSB > 0) begin : g_lo_bits
      logic unused_id_lo;
      assign unused_id_lo = ^dev_id[SLOT_LSB-1:0];
   end
   if (SLOT_HI < ID_W) begin : g_hi_bits
      logic unused_id_hi;
      assign unused_id_hi = ^dev_id[ID_W-1:SLOT_HI];
   end
endmodule

// File: rtl/irqsw_line_merge.sv
`timescale 1ns/1ps
// Wired-OR of all per-source one-hot requests onto the shared lines.
module irqsw_line_merge
   import irqsw_pkg::*;
#(
   parameter int N_SRC = 6
) (
   input  logic [N_SRC*LINES-1:0] req_flat,
   output lines_t                 any_req
);
   always_comb begin
      any_req = '0;
      for (int s = 0; s < N_SRC; s++) begin
         any_req = any_req | req_flat[s*LINES +: LINES];
      end
   end
endmodule

// File: rtl/irqsw_line_reg.sv
`timescale 1ns/1ps
// Output stage for the line levels, cleared by synchronous reset.
module irqsw_line_reg
   import irqsw_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  lines_t d,
   output lines_t q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end
endmodule

// File: rtl/irqsw_vec_table.sv
`timescale 1ns/1ps
// Controller input number per line: a base value plus the line index.
module irqsw_vec_table
   import irqsw_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 'h1B
) (
   output logic [LINES*VEC_W-1:0] line_vec
);
   if (VEC_BASE <= 0) begin : g_bad_base
      $error("irqsw_vec_table: controller input numbers must be non-zero");
   end
   if (VEC_BASE + LINES - 1 >= (1 << VEC_W)) begin : g_bad_width
      $error("irqsw_vec_table: VEC_W too narrow for the number table");
   end

   for (genvar k = 0; k < LINES; k++) begin : g_num
      assign line_vec[k*VEC_W +: VEC_W] = VEC_W'(VEC_BASE + k);
   end
endmodule

// File: rtl/intx_swizzle_router.sv
`timescale 1ns/1ps
module intx_swizzle_router
   import irqsw_pkg::*;
#(
   parameter int N_SRC    = 6,
   parameter int ID_W     = 16,
   parameter int SLOT_LSB = 11,
   parameter int SLOT_W   = 5,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 'h1B
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [N_SRC-1:0]       src_level,
   input  logic [N_SRC*ID_W-1:0]  src_id,
   input  logic [N_SRC*PIN_W-1:0] src_pin,
   output logic [LINES-1:0]       line_level,
   output logic [LINES*VEC_W-1:0] line_vec
);
   if (N_SRC < 1) begin : g_bad_count
      $error("intx_swizzle_router: N_SRC must be at least 1");
   end

   logic [N_SRC*LINES-1:0] req_flat;
   lines_t                 merged;

   for (genvar s = 0; s < N_SRC; s++) begin : g_lane
      irqsw_lane_decode #(
         .ID_W     (ID_W),
         .SLOT_LSB (SLOT_LSB),
         .SLOT_W   (SLOT_W)
      ) u_dec (
         .dev_id (src_id[s*ID_W +: ID_W]),
         .pin    (src_pin[s*PIN_W +: PIN_W]),
         .level  (src_level[s]),
         .req    (req_flat[s*LINES +: LINES])
      );
   end

   irqsw_line_merge #(.N_SRC(N_SRC)) u_merge (
      .req_flat (req_flat),
      .any_req  (merged)
   );

   irqsw_line_reg u_reg (
      .clk (clk),
      .rst (rst),
      .d   (merged),
      .q   (line_level)
   );

   irqsw_vec_table #(
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE)
   ) u_tab (
      .line_vec (line_vec)
   );
endmodule

// File: rtl/irqsw_checker.sv
`timescale 1ns/1ps
module irqsw_checker
   import irqsw_pkg::*;
#(
   parameter int N_SRC = 6,
   parameter int ID_W  = 16
) (
   input logic                   clk,
   input logic                   rst,
   input logic [N_SRC-1:0]       src_level,
   input logic [N_SRC*ID_W-1:0]  src_id,
   input logic [N_SRC*PIN_W-1:0] src_pin,
   input logic [LINES-1:0]       line_level
);
   // Edges since reset, saturating at 3; 0 means the previous edge was reset.
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (rst) begin
         age <= 2'd0;
      end else if (age != 2'd3) begin
         age <= age + 2'd1;
      end
   end

   // R8: lines are low in the cycle after a reset edge.
   p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd0) |-> (line_level == '0));

   // R6: with every source low, every line is low one cycle later.
   p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && $past(src_level) == '0) |-> (line_level == '0));

   // R5: each source lights at most one line.
   p_fanout_bound_r5: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0) |-> ($countones(line_level) <= $countones($past(src_level))));

   // R2: a lone active source lights exactly one line.
   p_single_line_r2: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && $countones($past(src_level)) == 1)
      |-> ($countones(line_level) == 1));

   // R7: inputs steady for two cycles keep the lines steady.
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && $past(src_level) == $past(src_level, 2)
       && $past(src_id) == $past(src_id, 2)
       && $past(src_pin) == $past(src_pin, 2))
      |-> $stable(line_level));
endmodule

bind intx_swizzle_router irqsw_checker #(
   .N_SRC (N_SRC),
   .ID_W  (ID_W)
) u_irqsw_chk (
   .clk        (clk),
   .rst        (rst),
   .src_level  (src_level),
   .src_id     (src_id),
   .src_pin    (src_pin),
   .line_level (line_level)
);

// File: tb/intx_swizzle_router_bench.sv
`timescale 1ns/1ps
module intx_swizzle_router_bench;
   localparam int NS = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NS-1:0] src_level = '0;
   logic [NS*16-1:0] src_id = '0;
   logic [NS*2-1:0]  src_pin = '0;
   logic [3:0]    line_level;
   logic [31:0]   line_vec;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   intx_swizzle_router u_intx_swizzle_router (
      .clk        (clk),
      .rst        (rst),
      .src_level  (src_level),
      .src_id     (src_id),
      .src_pin    (src_pin),
      .line_level (line_level),
      .line_vec   (line_vec)
   );

   typedef struct packed {
      logic [29:0] slots;  // {s5,s4,s3,s2,s1,s0}
      logic [11:0] pins;   // {p5,...,p0}
      logic [5:0]  lvl;
      logic [3:0]  exp;
   } vec_t;

   localparam vec_t VECS [10] = '{
      // 0: R2 slot 0 pin 0 -> index 0
      '{slots:30'd0, pins:12'd0, lvl:6'b000001, exp:4'b0001},
      // 1: R2 slot 1 pin 2 -> index 3
      '{slots:{25'd0, 5'd1}, pins:{10'd0, 2'd2}, lvl:6'b000001, exp:4'b1000},
      // 2: R10 slot 3 pin 3 -> index 2
      '{slots:{25'd0, 5'd3}, pins:{10'd0, 2'd3}, lvl:6'b000001, exp:4'b0100},
      // 3: R9 slot 31 pin 1 -> index 0
      '{slots:{25'd0, 5'd31}, pins:{10'd0, 2'd1}, lvl:6'b000001, exp:4'b0001},
      // 4: R9 slot 4 pin 1 -> index 1
      '{slots:{25'd0, 5'd4}, pins:{10'd0, 2'd1}, lvl:6'b000001, exp:4'b0010},
      // 5: R5 src0,src1 -> index 2, src2 -> index 3
      '{slots:{5'd0,5'd0,5'd0,5'd0,5'd1,5'd2}, pins:{2'd0,2'd0,2'd0,2'd3,2'd1,2'd0},
        lvl:6'b000111, exp:4'b1100},
      // 6: R6 src0 released, src1 still holds index 2
      '{slots:{5'd0,5'd0,5'd0,5'd0,5'd1,5'd2}, pins:{2'd0,2'd0,2'd0,2'd3,2'd1,2'd0},
        lvl:6'b000110, exp:4'b1100},
      // 7: R6 only src2 left -> index 3
      '{slots:{5'd0,5'd0,5'd0,5'd0,5'd1,5'd2}, pins:{2'd0,2'd0,2'd0,2'd3,2'd1,2'd0},
        lvl:6'b000100, exp:4'b1000},
      // 8: R5 all six active over all four lines
      '{slots:{5'd9,5'd5,5'd0,5'd0,5'd0,5'd0}, pins:{2'd0,2'd2,2'd3,2'd2,2'd1,2'd0},
        lvl:6'b111111, exp:4'b1111},
      // 9: R6 all released
      '{slots:{5'd9,5'd5,5'd0,5'd0,5'd0,5'd0}, pins:{2'd0,2'd2,2'd3,2'd2,2'd1,2'd0},
        lvl:6'b000000, exp:4'b0000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // Slot field at bits 15:11; filler bits below it must not matter (R1).
   function automatic logic [15:0] make_id(input logic [4:0] slot, input int i);
      return {slot, 11'(11'h5A5 ^ (i * 11'h13B))};
   endfunction

   initial begin
      #(200000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      chk("R8 lines low out of reset", 32'(line_level), 32'h0);
      rst = 1'b0;

      // R3: controller input numbers per line index.
      for (int k = 0; k < 4; k++) begin
         chk("R3 controller input number", 32'(line_vec[k*8 +: 8]), 32'(8'h1B + k));
      end

      // Table walk: R2, R5, R6, R9, R10.
      for (int v = 0; v < 10; v++) begin
         for (int i = 0; i < NS; i++) begin
            src_id[i*16 +: 16] = make_id(VECS[v].slots[i*5 +: 5], i + v);
            src_pin[i*2 +: 2]  = VECS[v].pins[i*2 +: 2];
         end
         src_level = VECS[v].lvl;
         @(negedge clk);
         chk($sformatf("R2/R5/R6/R9/R10 table vector %0d", v), 32'(line_level),
             32'(VECS[v].exp));
      end

      // R1: slot field position; bits below it all ones, slot 0 -> index 0.
      src_level = '0;
      src_pin   = '0;
      src_id    = '0;
      src_id[15:0] = 16'h07FF;
      src_level[0] = 1'b1;
      @(negedge clk);
      chk("R1 low filler bits ignored", 32'(line_level), 32'h1);
      src_id[15:0] = 16'h0800;   // slot 1 -> index 1
      @(negedge clk);
      chk("R1 slot field lsb at bit 11", 32'(line_level), 32'h2);

      // R4 and R7: lone source rise, then fall, with one cycle latency.
      src_level = '0;
      @(negedge clk);
      chk("R4 line low with source low", 32'(line_level), 32'h0);
      src_id[15:0] = 16'h1000;   // slot 2, pin 1 -> index 3
      src_pin[1:0] = 2'd1;
      src_level[0] = 1'b1;
      #1.25;
      chk("R7 no change before the edge", 32'(line_level), 32'h0);
      @(negedge clk);
      chk("R4 R7 line high after one edge", 32'(line_level), 32'h8);
      src_level[0] = 1'b0;
      #1.25;
      chk("R7 still high before the edge", 32'(line_level), 32'h8);
      @(negedge clk);
      chk("R4 line low after release", 32'(line_level), 32'h0);

      // R8: reset clears lit lines.
      src_level = '1;
      @(negedge clk);
      chk("R8 lines lit before reset", 32'(line_level != 4'h0), 32'h1);
      rst = 1'b1;
      @(negedge clk);
      chk("R8 reset clears lines", 32'(line_level), 32'h0);
      rst = 1'b0;
      src_level = '0;
      @(negedge clk);
      @(negedge clk);
      report();
   end
endmodule